// File: doc/BRIEF.md
# One-Shot Waveform Generator

This block drives a single output bit through one waveform after every reset or clear, and never repeats it by itself. An elaboration-time mode selects the waveform shape.

- **Impulse:** the output rests at 0, goes to 1 for a set number of cycles, then drops back to 0.
- **Step up:** the output rests at 0 and goes to 1 for good.
- **Step down:** the output rests at 1 and goes to 0 for good.

The delay and the pulse length are parameters. Both are counted in enabled clock cycles.

The same saturating counter serves all three modes. A small decoder turns the count into the output level. A clock-enable input and a synchronous clear input are each switched in or out by a parameter. When one of them is switched out, its port is still present but has no effect.

Typical uses are a power-up strobe, a delayed release of a downstream block, or a timed gate that a controller restarts by pulsing clear.

Top module: `pulse_gen_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the output shows the idle level of the mode: 0 for impulse and step up, 1 for step down.
- R2: Impulse mode with delay D ≥ 1 and length L ≥ 1: after k enabled edges since reset or clear, the output is 1 for D ≤ k < D+L and 0 otherwise.
- R3: Step-up mode: after k enabled edges since reset or clear, the output is 1 for k ≥ D and 0 otherwise.
- R4: Step-down mode: after k enabled edges since reset or clear, the output is 0 for k ≥ D and 1 otherwise.
- R5: A delay parameter of 0 behaves exactly like a delay of 1: the transition is visible after the first enabled edge.
- R6: Impulse mode with length 0 never drives the output to 1.
- R7: With the enable in use, an edge with `en` low (and `clr` low) leaves the output and the sequence position unchanged.
- R8: With the clear in use, an edge with `clr` high returns the output to the idle level and restarts the sequence, whatever the value of `en`.
- R9: Once the sequence ends, the output keeps its final level under any number of further enabled edges, until the next clear or reset.
- R10: With the enable switched out, every edge counts as enabled. With the clear switched out, `clr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable (used only when USE_EN=1) |
| clr | input | 1 | Synchronous clear, active high (used only when USE_CLR=1) |
| pulse_o | output | 1 | Waveform output |

## Verification
The output is decoded directly from the counter register. Any rising edge that sees reset, clear or enable therefore shows its result on `pulse_o` one cycle later, with no further latency.

The bench drives inputs on the falling edge and updates its own reference position at the rising edge. It compares every instance on the following falling edge, which is exactly the cycle in which the new level is due.

Five instances run side by side under the same stimulus, each with different parameters. This lets a single pattern of enable, clear and reset exercise every mode together with its corner settings.

// File: rtl/pulse_gen_pkg.sv
// Package: shared types for the one-shot waveform generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pulse_gen_pkg;

    // Waveform shape selected at elaboration.
    typedef enum logic [1:0] {
        MODE_IMPULSE   = 2'd0,
        MODE_STEP_UP   = 2'd1,
        MODE_STEP_DOWN = 2'd2
    } pulse_mode_e;

endpackage

// File: rtl/pulse_gen_counter.sv
// Module: saturating position counter.
// Counts enabled edges from 0 up to LIMIT, then stops.
// A clear or reset restarts it at 0; clear wins over enable.
// Assumes: LIMIT >= 1 and CW wide enough to hold LIMIT.
module pulse_gen_counter #(
    parameter int CW    = 4,
    parameter int LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          restart,
    output logic [CW-1:0] pos
);

    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    // Position register: reset/clear to 0, step until the limit, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos <= '0;
        end else if (step && (pos != LIM_C)) begin
            pos <= pos + 1'b1;
        end
    end

    // R9: the counter never passes its limit.
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LIM_C);

    // R9: once at the limit, it stays there unless restarted.
    a_r9_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LIM_C && !restart) |=> pos == LIM_C);

    // R8: a restart returns the position to zero on the next cycle.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pos == '0);

    // R7: without step or restart, the position is frozen.
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(pos));

endmodule

// File: rtl/pulse_gen_shaper.sv
// Module: maps a sequence position onto the output level of the mode.
// Pure combinational decode.
// Assumes: D_EFF >= 1, and position counts enabled edges since restart.
module pulse_gen_shaper
    import pulse_gen_pkg::*;
#(
    parameter pulse_mode_e MODE   = MODE_IMPULSE,
    parameter int          CW     = 4,
    parameter int          D_EFF  = 1,
    parameter int          LENGTH = 1
) (
    input  logic [CW-1:0] pos,
    output logic          level
);

    localparam logic [CW-1:0] D_C = CW'(D_EFF);
    localparam logic [CW-1:0] E_C = CW'(D_EFF + LENGTH);

    // Level decode: idle level before the delay, active window or final level after.
    always_comb begin
        case (MODE)
            MODE_IMPULSE:   level = (pos >= D_C) && (pos < E_C);
            MODE_STEP_UP:   level = (pos >= D_C);
            MODE_STEP_DOWN: level = !(pos >= D_C);
            default:        level = 1'b0;
        endcase
    end

endmodule

// File: rtl/pulse_gen_top.sv
// Module: one-shot waveform generator top.
// Gates the optional enable and clear, runs the saturating counter,
// and decodes the output level.
// Assumes: DELAY >= 0 (0 acts as 1), LENGTH >= 0, synchronous active-low reset.
module pulse_gen_top
    import pulse_gen_pkg::*;
#(
    parameter pulse_mode_e MODE    = MODE_IMPULSE,
    parameter int          DELAY   = 5,
    parameter int          LENGTH  = 3,
    parameter bit          USE_EN  = 1'b1,
    parameter bit          USE_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic pulse_o
);

    localparam int D_EFF = (DELAY < 1) ? 1 : DELAY;
    localparam int LAST  = (MODE == MODE_IMPULSE) ? (D_EFF + LENGTH) : D_EFF;
    localparam int CW    = $clog2(LAST + 1);

    logic          step_en;
    logic          restart;
    logic [CW-1:0] pos;

    // Enable path: the port when in use, otherwise every cycle counts.
    generate
        if (USE_EN) begin : g_en
            assign step_en = en;
        end else begin : g_no_en
            assign step_en = 1'b1;
        end
    endgenerate

    // Clear path: the port when in use, otherwise tied off.
    generate
        if (USE_CLR) begin : g_clr
            assign restart = clr;
        end else begin : g_no_clr
            assign restart = 1'b0;
        end
    endgenerate

    pulse_gen_counter #(
        .CW    (CW),
        .LIMIT (LAST)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_en),
        .restart (restart),
        .pos     (pos)
    );

    pulse_gen_shaper #(
        .MODE   (MODE),
        .CW     (CW),
        .D_EFF  (D_EFF),
        .LENGTH (LENGTH)
    ) u_shaper (
        .pos   (pos),
        .level (pulse_o)
    );

    // R1: the cycle after reset shows the idle level of the mode.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> pulse_o == (MODE == MODE_STEP_DOWN));

    // R8: a clear brings back the idle level.
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pulse_o == (MODE == MODE_STEP_DOWN));

    // Per-mode output properties.
    generate
        if (MODE == MODE_STEP_UP) begin : g_chk_up
            // R3: once high, step-up output stays high until cleared.
            a_r3_step_up_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (pulse_o && !restart) |=> pulse_o);
        end else if (MODE == MODE_STEP_DOWN) begin : g_chk_down
            // R4: once low, step-down output stays low until cleared.
            a_r4_step_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (!pulse_o && !restart) |=> !pulse_o);
        end else if (LENGTH == 0) begin : g_chk_zero
            // R6: a zero-length impulse never raises the output.
            a_r6_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                !pulse_o);
        end
    endgenerate

endmodule

// File: tb/pulse_gen_top_tb_top.sv
// Bench: five generator instances share one stimulus.
// Each instance is checked against a reference model built from the requirements.
module pulse_gen_top_tb_top;
    import pulse_gen_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NDUT       = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic en;
    logic clr;
    logic [NDUT-1:0] q;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Instances: impulse, step up, step down with delay 0,
    // zero-length impulse, and impulse with enable and clear switched out.
    pulse_gen_top #(.MODE(MODE_IMPULSE),   .DELAY(5), .LENGTH(3), .USE_EN(1'b1), .USE_CLR(1'b1))
        dut_i (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pulse_o(q[0]));
    pulse_gen_top #(.MODE(MODE_STEP_UP),   .DELAY(4), .LENGTH(0), .USE_EN(1'b1), .USE_CLR(1'b1))
        dut_up (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pulse_o(q[1]));
    pulse_gen_top #(.MODE(MODE_STEP_DOWN), .DELAY(0), .LENGTH(0), .USE_EN(1'b1), .USE_CLR(1'b1))
        dut_dn (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pulse_o(q[2]));
    pulse_gen_top #(.MODE(MODE_IMPULSE),   .DELAY(2), .LENGTH(0), .USE_EN(1'b1), .USE_CLR(1'b1))
        dut_z (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pulse_o(q[3]));
    pulse_gen_top #(.MODE(MODE_IMPULSE),   .DELAY(3), .LENGTH(2), .USE_EN(1'b0), .USE_CLR(1'b0))
        dut_nc (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pulse_o(q[4]));

    // Reference parameters, indexed by instance.
    int m_mode [NDUT] = '{0, 1, 2, 0, 0};
    int m_dly  [NDUT] = '{5, 4, 0, 2, 3};
    int m_len  [NDUT] = '{3, 0, 0, 0, 2};
    bit m_ue   [NDUT] = '{1, 1, 1, 1, 0};
    bit m_uc   [NDUT] = '{1, 1, 1, 1, 0};
    string m_tag [NDUT] = '{"R2", "R3", "R4/R5", "R6", "R10"};
    int k [NDUT];

    // Expected output level after n enabled edges since restart.
    function automatic bit exp_level(int mode, int dly, int len, int n);
        int d;
        d = (dly < 1) ? 1 : dly;
        case (mode)
            0:       return (n >= d) && (n < d + len);
            1:       return n >= d;
            default: return !(n >= d);
        endcase
    endfunction

    // Advance the reference positions for one rising edge.
    function automatic void model_edge(bit r_n, bit e, bit c);
        for (int i = 0; i < NDUT; i++) begin
            int lim;
            lim = ((m_dly[i] < 1) ? 1 : m_dly[i]) + ((m_mode[i] == 0) ? m_len[i] : 0);
            if (!r_n || (c && m_uc[i])) k[i] = 0;
            else if ((e || !m_ue[i]) && k[i] < lim) k[i] = k[i] + 1;
        end
    endfunction

    // Compare every instance; tag overrides the per-instance requirement if set.
    task automatic check_all(string tag);
        for (int i = 0; i < NDUT; i++) begin
            bit e;
            string t;
            e = exp_level(m_mode[i], m_dly[i], m_len[i], k[i]);
            t = (tag == "") ? m_tag[i] : tag;
            tests_run++;
            if (q[i] !== e) begin
                tests_failed++;
                $display("FAIL %s inst %0d k=%0d: got %0b expected %0b", t, i, k[i], q[i], e);
            end
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, check at the next falling edge.
    task automatic cycle(bit r_n, bit e, bit c, string tag);
        rst_n = r_n; en = e; clr = c;
        @(posedge clk);
        model_edge(r_n, e, c);
        @(negedge clk);
        check_all(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 50000);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        rst_n = 1'b0; en = 1'b0; clr = 1'b0;
        @(negedge clk);
        // R1: reset state
        cycle(1'b0, 1'b1, 1'b0, "R1");
        cycle(1'b0, 1'b0, 1'b1, "R1");
        // Main sequences with enable held high; later cycles exercise saturation (R9).
        for (int j = 0; j < 8; j++) cycle(1'b1, 1'b1, 1'b0, "");
        for (int j = 0; j < 6; j++) cycle(1'b1, 1'b1, 1'b0, "R9");
        // R8: clear with enable high restarts.
        cycle(1'b1, 1'b1, 1'b1, "R8");
        cycle(1'b1, 1'b1, 1'b0, "");
        cycle(1'b1, 1'b1, 1'b0, "");
        // R7: enable low freezes the sequence mid-way.
        for (int j = 0; j < 4; j++) cycle(1'b1, 1'b0, 1'b0, "R7");
        for (int j = 0; j < 4; j++) cycle(1'b1, 1'b1, 1'b0, "");
        // R8: clear with enable low also restarts.
        cycle(1'b1, 1'b0, 1'b1, "R8");
        // Random mix of enable, clear and occasional reset.
        for (int j = 0; j < 400; j++) begin
            bit e, c, r;
            e = ($urandom % 4) != 0;
            c = ($urandom % 25) == 0;
            r = ($urandom % 97) != 0;
            cycle(r, e, c, "");
        end
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule